// File: doc/BRIEF.md
# ADC calibration sequence controller

This block is the digital sequencer that runs the calibration steps of a 20-bit converter. It watches a single calibrate request line. A request counts only when the line has been high for enough clock cycles and then drops. The two mode-select bits are captured when the line rises. On the drop, the block starts a step of fixed length that belongs to the chosen mode. While the step runs, the active-low data-ready output is held high. When the step ends, data-ready falls and the result word is published.

Four calibration kinds are supported:
- a one-step self-calibration;
- a one-step system offset;
- the offset and gain halves of a two-step system calibration.

The gain half is refused unless the offset half has just completed. A request that ends while a step is running is dropped and raises a sticky error. The bipolar/unipolar select is not latched. Changing it after a calibration raises a flag that stays up until the next step completes. The analog modulator, the filter and the real offset/gain arithmetic are outside this block. A measurement input stands in for the filter output.

Top module: `cal_sequencer`

## Requirements
- R1: A request is qualified when `cal_req` was sampled high on at least MIN_HI consecutive rising edges and is then sampled low. The step starts on that edge. A shorter pulse starts nothing and sets no error.
- R2: The mode {`sel_a`,`sel_b`} is captured on the clock edge where `cal_req` is first sampled high. Changing the select bits later in the same pulse has no effect.
- R3: The mode codes are as follows. `busy` is high for exactly that many cycles, and `act_mode` shows the mode code during the step.

  | Code | Step | Duration |
  |------|------|----------|
  | 00 | self-calibration | T_SELF |
  | 11 | offset half of the two-step system calibration | T_OFF2 |
  | 01 | gain half of the two-step system calibration | T_GAIN |
  | 10 | one-step system offset | T_OFF1 |

- R4: `rdy_n` goes high when a step starts and stays high through the step. It goes low on the edge the step completes.
- R5: A qualified request whose end is sampled while a step runs is ignored: the running step and its result are unchanged. It sets the sticky `err` flag.
- R6: A gain request (01) is accepted only when the last completed step was an offset half (11) and no step has started since. Otherwise it is rejected, starts nothing and sets `err`.
- R7: On completion, `result` is loaded as follows:
  - all zeros after mode 11 or 10;
  - all ones after mode 01;
  - the value of `meas` after mode 00.
- R8: Once any step has completed since reset, a change of `bipolar` sets `recal`. `recal` clears when a step completes. If a change and a completion fall on the same edge, the set wins. Before the first completion, changes of `bipolar` are ignored.
- R9: A synchronous reset sets the following. After reset, `rdy_n` stays high until the first step completes.

  | Output | Value after reset |
  |--------|-------------------|
  | `rdy_n` | 1 |
  | `busy` | 0 |
  | `act_mode` | 0 |
  | `err` | 0 |
  | `recal` | 0 |
  | `result` | 0 |

- R10: A request whose end is sampled on the same edge as a step's completion is rejected under R5. The completing step still publishes its own result, and no new step starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | Calibrate request |
| sel_a | input | 1 | Mode select, upper bit |
| sel_b | input | 1 | Mode select, lower bit |
| bipolar | input | 1 | Bipolar (1) / unipolar (0) select, not latched |
| meas | input | DW | Stand-in for the filtered measurement |
| rdy_n | output | 1 | Active-low data ready |
| result | output | DW | Published result word |
| busy | output | 1 | Step in progress |
| act_mode | output | 2 | Mode of the running step, 0 when idle |
| err | output | 1 | Sticky rejected-request flag |
| recal | output | 1 | Recalibration required |

## Verification
Two collisions matter here. The first is the end of a new request arriving on the very edge a step completes. The bench times a second pulse so that its low level is first sampled on the completion edge. It then checks two things: the step published its own zero result with `rdy_n` low, and the new request was refused with `err` set and no restart. The second collision is a toggle of `bipolar` landing on a completion edge. The bench expects `recal` to read 1 afterwards. Durations, mode order and results are swept over all four modes and several pulse widths, with expected values from a small model.

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int DW     = 20,
  parameter int MIN_HI = 4,
  parameter int T_SELF = 3145655,
  parameter int T_OFF2 = 1052599,
  parameter int T_GAIN = 1068813,
  parameter int T_OFF1 = 2117389
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cal_req,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          bipolar,
  input  logic [DW-1:0] meas,
  output logic          rdy_n,
  output logic [DW-1:0] result,
  output logic          busy,
  output logic [1:0]    act_mode,
  output logic          err,
  output logic          recal
);
  localparam int TM1  = (T_SELF > T_OFF2) ? T_SELF : T_OFF2;
  localparam int TM2  = (T_GAIN > T_OFF1) ? T_GAIN : T_OFF1;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int HW   = $clog2(MIN_HI + 1);

  localparam logic [1:0] M_SELF = 2'b00;
  localparam logic [1:0] M_GAIN = 2'b01;
  localparam logic [1:0] M_OFF1 = 2'b10;
  localparam logic [1:0] M_OFF2 = 2'b11;

  logic          req_q, bip_q, off_done, cal_ok;
  logic [HW-1:0] hi_cnt;
  logic [1:0]    pend_mode, cur_mode;
  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] dur_m1(input logic [1:0] m);
    case (m)
      M_SELF:  return CW'(T_SELF - 1);
      M_GAIN:  return CW'(T_GAIN - 1);
      M_OFF1:  return CW'(T_OFF1 - 1);
      default: return CW'(T_OFF2 - 1);
    endcase
  endfunction

  wire req_rise = cal_req & ~req_q;
  wire req_end  = ~cal_req & req_q & (hi_cnt >= HW'(MIN_HI));
  wire gain_bad = (pend_mode == M_GAIN) & ~off_done;
  wire start    = req_end & ~busy & ~gain_bad;
  wire reject   = req_end & (busy | gain_bad);
  wire finish   = busy & (cnt == '0);

  assign act_mode = busy ? cur_mode : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      hi_cnt    <= '0;
      pend_mode <= 2'b00;
      cur_mode  <= 2'b00;
      busy      <= 1'b0;
      cnt       <= '0;
      rdy_n     <= 1'b1;
      result    <= '0;
      err       <= 1'b0;
      off_done  <= 1'b0;
      cal_ok    <= 1'b0;
      bip_q     <= 1'b0;
      recal     <= 1'b0;
    end else begin
      req_q <= cal_req;
      bip_q <= bipolar;
      if (!cal_req)
        hi_cnt <= '0;
      else if (hi_cnt != HW'(MIN_HI))
        hi_cnt <= hi_cnt + 1'b1;
      if (req_rise)
        pend_mode <= {sel_a, sel_b};
      if (reject)
        err <= 1'b1;
      if (start) begin
        busy     <= 1'b1;
        cnt      <= dur_m1(pend_mode);
        cur_mode <= pend_mode;
        rdy_n    <= 1'b1;
        off_done <= 1'b0;
      end else if (finish) begin
        busy     <= 1'b0;
        rdy_n    <= 1'b0;
        cal_ok   <= 1'b1;
        off_done <= (cur_mode == M_OFF2);
        case (cur_mode)
          M_SELF:  result <= meas;
          M_GAIN:  result <= '1;
          default: result <= '0;
        endcase
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
      if (cal_ok && (bipolar != bip_q))
        recal <= 1'b1;
      else if (finish)
        recal <= 1'b0;
    end
  end

  // R4
  busy_rdy_chk: assert property (@(posedge clk) disable iff (rst) busy |-> rdy_n);
  // R4
  done_rdy_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> !rdy_n);
  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !$past(cal_req));
  // R7
  zero_res_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && cur_mode[1]) |-> (result == '0));
  // R7
  ones_res_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && cur_mode == M_GAIN) |-> (result == '1));
  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);
  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(act_mode));
endmodule

// File: tb/sim_cal_sequencer.sv
module sim_cal_sequencer;
  localparam int CLK_P  = 10;
  localparam int DW     = 20;
  localparam int MIN_HI = 4;
  localparam int T_SELF = 12;
  localparam int T_OFF2 = 5;
  localparam int T_GAIN = 7;
  localparam int T_OFF1 = 9;

  logic clk = 0, rst = 1, cal_req = 0, sel_a = 0, sel_b = 0, bipolar = 0;
  logic [DW-1:0] meas = '0;
  logic rdy_n, busy, err, recal;
  logic [DW-1:0] result;
  logic [1:0] act_mode;

  cal_sequencer #(.DW(DW), .MIN_HI(MIN_HI), .T_SELF(T_SELF), .T_OFF2(T_OFF2),
                  .T_GAIN(T_GAIN), .T_OFF1(T_OFF1)) u0 (
    .clk(clk), .rst(rst), .cal_req(cal_req), .sel_a(sel_a), .sel_b(sel_b),
    .bipolar(bipolar), .meas(meas), .rdy_n(rdy_n), .result(result),
    .busy(busy), .act_mode(act_mode), .err(err), .recal(recal));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  logic e_off = 0, e_err = 0, e_rdy = 1;
  logic [DW-1:0] e_res = '0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic int dur(input logic [1:0] m);
    case (m)
      2'b00: return T_SELF;
      2'b01: return T_GAIN;
      2'b10: return T_OFF1;
      default: return T_OFF2;
    endcase
  endfunction

  function automatic logic [DW-1:0] res_of(input logic [1:0] m, input logic [DW-1:0] v);
    if (m == 2'b00) return v;
    if (m == 2'b01) return '1;
    return '0;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1; cal_req = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    e_off = 0; e_err = 0; e_rdy = 1; e_res = '0;
  endtask

  task automatic pulse(input logic [1:0] m, input int w);
    @(negedge clk); {sel_a, sel_b} = m; cal_req = 1;
    repeat (w) @(negedge clk);
    cal_req = 0;
  endtask

  task automatic run_one(input logic [1:0] m, input int w, input logic [DW-1:0] v);
    int d;
    meas = v;
    pulse(m, w);
    @(posedge clk); @(negedge clk);
    if (w < MIN_HI) begin
      chk("R1 short busy", busy, 0);
      chk("R1 short err", err, e_err);
      chk("R9 rdy held", rdy_n, e_rdy);
    end else if (m == 2'b01 && !e_off) begin
      e_err = 1;
      chk("R6 gain reject busy", busy, 0);
      chk("R6 gain reject err", err, 1);
    end else begin
      e_off = 0;
      chk("R4 start rdy", rdy_n, 1);
      chk("R3 act_mode", act_mode, m);
      d = dur(m);
      repeat (d - 1) @(negedge clk);
      chk("R3 busy last", busy, 1);
      @(negedge clk);
      chk("R3 busy end", busy, 0);
      chk("R4 done rdy", rdy_n, 0);
      e_res = res_of(m, v);
      e_rdy = 0;
      e_off = (m == 2'b11);
      chk("R7 result", result, e_res);
      chk("R5 err", err, e_err);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] seq [8];
    seq = '{2'b00, 2'b01, 2'b11, 2'b01, 2'b01, 2'b10, 2'b11, 2'b00};
    do_reset();
    @(negedge clk);
    chk("R9 rdy_n", rdy_n, 1);
    chk("R9 busy", busy, 0);
    chk("R9 err", err, 0);
    chk("R9 recal", recal, 0);
    chk("R9 result", result, 0);
    chk("R9 act_mode", act_mode, 0);

    // R1 R3 R6 R7 sweep
    for (int i = 0; i < 8; i++)
      for (int w = 2; w <= 5; w++)
        run_one(seq[i], w, DW'(32'h3A5C1 + i * 32'h1111 + w));

    // R2 select change mid-pulse
    do_reset();
    @(negedge clk); {sel_a, sel_b} = 2'b00; cal_req = 1;
    @(negedge clk); {sel_a, sel_b} = 2'b11;
    repeat (4) @(negedge clk); cal_req = 0;
    @(posedge clk); @(negedge clk);
    chk("R2 mode kept", act_mode, 2'b00);
    repeat (T_SELF - 1) @(negedge clk);
    chk("R2 duration", busy, 1);
    @(negedge clk);
    chk("R2 done", busy, 0);

    // R5 request during step
    do_reset();
    pulse(2'b10, 4);
    @(posedge clk); @(negedge clk);
    pulse(2'b11, 4);
    @(posedge clk); @(negedge clk);
    chk("R5 still busy", busy, 1);
    chk("R5 err set", err, 1);
    chk("R5 mode kept", act_mode, 2'b10);
    repeat (2) @(negedge clk);
    chk("R5 busy k8", busy, 1);
    @(negedge clk);
    chk("R5 finish", busy, 0);
    chk("R5 result", result, 0);
    e_off = 0; e_err = 1; e_rdy = 0; e_res = '0;
    run_one(2'b01, 4, '0);
    chk("R6 no offset done", busy, 0);

    // R10 request end on completion edge
    do_reset();
    pulse(2'b10, 4);
    @(posedge clk); @(negedge clk);
    repeat (3) @(negedge clk);
    pulse(2'b00, 4);
    @(posedge clk); @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 rdy", rdy_n, 0);
    chk("R10 err", err, 1);
    chk("R10 result", result, 0);
    repeat (3) @(negedge clk);
    chk("R10 no restart", busy, 0);

    // R8 recal flag
    do_reset();
    @(negedge clk); bipolar = 1;
    repeat (2) @(negedge clk);
    chk("R8 ignored before cal", recal, 0);
    run_one(2'b00, 4, 20'hABCDE);
    chk("R8 clear", recal, 0);
    @(negedge clk); bipolar = 0;
    @(negedge clk);
    chk("R8 set", recal, 1);
    run_one(2'b10, 4, '0);
    chk("R8 cleared by cal", recal, 0);
    pulse(2'b10, 4);
    @(posedge clk); @(negedge clk);
    repeat (T_OFF1 - 1) @(negedge clk);
    bipolar = 1;
    @(negedge clk);
    chk("R8 done edge", busy, 0);
    chk("R8 set wins", recal, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule